// File: doc/BRIEF.md
# Configurable Audio Slot Serializer

This block is the transmit side of a master-mode serial audio port. It generates its own bit clock from the system clock and sends a frame of two 32-bit slots on a serial data line. A frame-sync line marks the first slot of each frame. Samples arrive through a small internal FIFO with a valid/ready handshake. Each slot carries one sample, left-aligned in time. The sample width is chosen by a 3-bit size code, and the sample can go out with its most or least significant bit first.

The configuration inputs are sampled only while the block is fully stopped and are held for the whole run. The enable input starts the block. Once enable is dropped, the frame in progress always completes before the block stops. The enable status output reports when the stop has actually happened. A mono option spends one FIFO word per frame and sends it in both slots. If a slot starts while the FIFO is empty, that slot carries zeros and a one-cycle underrun flag is raised.

Top module: `audio_slot_tx`

## Requirements
- R1: Size code 2, 3, 4, 5, 6 and 7 select 8, 10, 16, 20, 24 and 32 data bits. The reserved codes 0 and 1 act as 16 bits. The sample's low W bits fill the first W bit times of the slot, and the remaining bit times of the slot are zero.
- R2: With `cfg_lsb_first` = 0, bit W-1 of the sample goes first. With 1, bit 0 goes first.
- R3: With `cfg_strobe_rise` = 0, `sd` and `fs` change only together with a rising `sck` edge, so the receiver samples on the falling edge. With 1, they change only on a falling edge and are sampled on the rising edge. When idle, `sck` rests at the level `cfg_strobe_rise` has.
- R4: A frame is two slots of 32 bit times each, sent back to back. `fs` is 1 throughout slot 0 and 0 throughout slot 1.
- R5: In stereo (`cfg_mono` = 0) each frame pops two FIFO words. The older word goes into slot 0 and the newer into slot 1.
- R6: In mono (`cfg_mono` = 1) each frame pops one FIFO word and sends it in both slots.
- R7: When `en_req` falls during a frame, that frame is sent in full. `en_status` stays 1 until the frame's last bit time has ended and then reads 0.
- R8: Raising `en_req` again while `en_status` is still 1 after a drop does not cancel the pending stop. The block still stops at the end of the current frame.
- R9: Configuration inputs are captured only while `en_status` is 0. Changes while running do not alter the frames being sent.
- R10: If the FIFO is empty when a slot needs a word, the slot sends zeros and `underrun` is 1 for exactly one clock cycle.
- R11: One bit time lasts `DIV` system clocks (`DIV` >= 2). `sck` spends DIV/2 clocks (rounded down) at the drive-edge level and the rest at the other level.
- R12: After reset, `en_status`, `fs`, `sd`, `underrun` and `sck` are 0 and `s_ready` is 1. The captured configuration resets to 16 bits, MSB first, falling-edge sampling, stereo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_req | input | 1 | Run request, level sensitive |
| cfg_size | input | 3 | Sample size code |
| cfg_lsb_first | input | 1 | 1: LSB sent first |
| cfg_strobe_rise | input | 1 | 1: receiver samples on rising sck |
| cfg_mono | input | 1 | 1: one word repeated in both slots |
| s_valid | input | 1 | Sample offered to the FIFO |
| s_data | input | 32 | Sample word |
| s_ready | output | 1 | FIFO has room |
| sck | output | 1 | Bit clock |
| fs | output | 1 | Frame sync, high during slot 0 |
| sd | output | 1 | Serial data |
| en_status | output | 1 | 1 while the block is running |
| underrun | output | 1 | One-cycle pulse on a slot start with an empty FIFO |

## Verification
The embedded assertions check several rules on every cycle. The FIFO never pops when empty. The bit-time counter stays inside its period. The captured configuration never moves while running. The run only ends right after the last bit time of slot 1. Mono pops happen only at frame starts. Frame sync changes only at bit boundaries, and an underrun pulse lasts one cycle. Only the bench scenarios can show what the serial line carries: the bit placement and order for each size code, the sampling-edge relation, how words are consumed in stereo and mono, and the stop timing when enable is dropped or re-raised.

// File: rtl/audio_tx_pkg.sv
// Package: shared constants, configuration struct and sample placement.
// Assumes a fixed 32-bit slot; the sample width is chosen per run.
package audio_tx_pkg;

    localparam int SLOT_BITS = 32;

    typedef struct packed {
        logic [2:0] size_code;
        logic       lsb_first;
        logic       strobe_rise;
        logic       mono;
    } tx_cfg_t;

    localparam tx_cfg_t CFG_RESET = '{size_code: 3'd4, lsb_first: 1'b0,
                                      strobe_rise: 1'b0, mono: 1'b0};

    // Sample width selected by a size code; reserved codes behave as 16 bits.
    function automatic int unsigned width_of(input logic [2:0] code);
        case (code)
            3'd2:    return 8;
            3'd3:    return 10;
            3'd5:    return 20;
            3'd6:    return 24;
            3'd7:    return 32;
            default: return 16;
        endcase
    endfunction

    // Slot word whose bit [SLOT_BITS-1] is sent first; unused tail is zero.
    function automatic logic [SLOT_BITS-1:0] place_sample(
        input logic [SLOT_BITS-1:0] smp,
        input logic [2:0]           code,
        input logic                 lsb_first);
        logic [SLOT_BITS-1:0] kept;
        logic [SLOT_BITS-1:0] rev;
        int unsigned          w;
        w = width_of(code);
        for (int i = 0; i < SLOT_BITS; i++) begin
            kept[i] = (i < int'(w)) ? smp[i] : 1'b0;
        end
        for (int i = 0; i < SLOT_BITS; i++) begin
            rev[SLOT_BITS-1-i] = kept[i];
        end
        return lsb_first ? rev : (kept << (SLOT_BITS - w));
    endfunction

endpackage

// File: rtl/audio_tx_fifo.sv
// Module: synchronous sample FIFO between the producer and the slot engine.
// Assumes: push is gated by the caller with ready; pop only when not empty.
// The head word is presented combinationally on rd_data.
module audio_tx_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             pop,
    output logic [WIDTH-1:0] rd_data,
    output logic             not_empty,
    output logic             not_full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    level;

    assign not_empty = (level != '0);
    assign not_full  = (level != CW'(DEPTH));
    assign rd_data   = mem[rd_ptr];

    // Pointer wrap helper for non-power-of-two depths.
    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wr_data;
    end

    // Pointer and fill-level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // R5: the engine never takes a word that is not there.
    assert_pop_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> not_empty)
        else $error("pop on empty FIFO");

    // R5: fill level never passes the depth.
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH))
        else $error("FIFO level beyond depth");

endmodule

// File: rtl/audio_sck_timer.sv
// Module: bit-time counter and bit clock generator.
// Assumes DIV >= 2. While run is low the counter holds at zero and sck
// rests at the sampling-side level; bit_end marks the last clock of a bit.
module audio_sck_timer #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic strobe_rise,
    output logic bit_end,
    output logic sck
);
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int HALF = DIV / 2;

    logic [CW-1:0] cnt;

    assign bit_end = run && (cnt == CW'(DIV - 1));
    // Drive-edge level during the first HALF clocks of every bit time.
    assign sck = (run && (cnt < CW'(HALF))) ^ strobe_rise;

    // Count system clocks within a bit time.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || bit_end) cnt <= '0;
        else                           cnt <= cnt + 1'b1;
    end

    // R11: the counter stays within one bit period.
    assert_cnt_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DIV - 1))
        else $error("bit counter out of range");

    // R11: a running bit time restarts only after a completed one.
    assert_period_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && cnt == '0) |-> $past(bit_end))
        else $error("bit time cut short");

endmodule

// File: rtl/audio_slot_engine.sv
// Module: frame/slot sequencer and output shift register.
// Assumes bit_end comes from a timer running off the same run flag.
// Configuration is tracked while stopped and frozen once running; a drop of
// en_req arms a stop that is taken at the next frame end.
module audio_slot_engine
    import audio_tx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_req,
    input  tx_cfg_t              cfg_in,
    input  logic                 bit_end,
    input  logic                 fifo_valid,
    input  logic [SLOT_BITS-1:0] fifo_data,
    output logic                 fifo_pop,
    output logic                 running,
    output logic                 strobe_rise,
    output logic                 fs,
    output logic                 sd,
    output logic                 underrun
);
    localparam int BW = $clog2(SLOT_BITS);
    localparam logic [BW-1:0] LAST_BIT = BW'(SLOT_BITS - 1);

    tx_cfg_t              cfg_q;
    logic                 run_q, stop_pend, slot_q, fs_q, urun_q;
    logic [BW-1:0]        bitc;
    logic [SLOT_BITS-1:0] shreg, held;

    logic                 slot_end, frame_end, stop_now;
    logic                 load0, load1, go_off, need_pop;
    logic                 eff_mono, eff_lsb;
    logic [2:0]           eff_size;
    logic [SLOT_BITS-1:0] fresh, slot_word;

    // Configuration in force: live inputs at start, frozen copy while running.
    always_comb begin
        eff_mono = run_q ? cfg_q.mono      : cfg_in.mono;
        eff_lsb  = run_q ? cfg_q.lsb_first : cfg_in.lsb_first;
        eff_size = run_q ? cfg_q.size_code : cfg_in.size_code;
    end

    // Slot and frame boundary decisions.
    always_comb begin
        slot_end  = bit_end && (bitc == LAST_BIT);
        frame_end = slot_end && slot_q;
        stop_now  = stop_pend || !en_req;
        load0     = (!run_q && en_req) || (frame_end && !stop_now);
        load1     = slot_end && !slot_q;
        go_off    = frame_end && stop_now;
        need_pop  = load0 || (load1 && !eff_mono);
        fresh     = fifo_valid ? fifo_data : '0;
        slot_word = place_sample((load1 && eff_mono) ? held : fresh,
                                 eff_size, eff_lsb);
    end

    assign fifo_pop    = need_pop && fifo_valid;
    assign running     = run_q;
    assign strobe_rise = cfg_q.strobe_rise;
    assign fs          = fs_q;
    assign sd          = shreg[SLOT_BITS-1];
    assign underrun    = urun_q;

    // Run flag, pending stop and configuration capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q     <= 1'b0;
            stop_pend <= 1'b0;
            cfg_q     <= CFG_RESET;
        end else begin
            if (load0)       run_q <= 1'b1;
            else if (go_off) run_q <= 1'b0;
            if (!run_q || go_off) stop_pend <= 1'b0;
            else if (!en_req)     stop_pend <= 1'b1;
            if (!run_q) cfg_q <= cfg_in;
        end
    end

    // Slot position, shift register, frame sync and underrun pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= 1'b0;
            bitc   <= '0;
            shreg  <= '0;
            held   <= '0;
            fs_q   <= 1'b0;
            urun_q <= 1'b0;
        end else begin
            urun_q <= need_pop && !fifo_valid;
            if (load0) begin
                slot_q <= 1'b0;
                bitc   <= '0;
                shreg  <= slot_word;
                held   <= fresh;
                fs_q   <= 1'b1;
            end else if (load1) begin
                slot_q <= 1'b1;
                bitc   <= '0;
                shreg  <= slot_word;
                fs_q   <= 1'b0;
            end else if (go_off) begin
                slot_q <= 1'b0;
                bitc   <= '0;
                shreg  <= '0;
                fs_q   <= 1'b0;
            end else if (bit_end) begin
                bitc   <= bitc + 1'b1;
                shreg  <= {shreg[SLOT_BITS-2:0], 1'b0};
            end
        end
    end

    // R7: the run ends only right after the last bit of slot 1.
    assert_stop_at_frame_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_q) |-> $past(slot_q && bitc == LAST_BIT && bit_end))
        else $error("stopped inside a frame");

    // R9: frozen configuration does not move while running.
    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q)) |-> $stable(cfg_q))
        else $error("configuration changed while running");

    // R6: in mono, words are taken only at a frame start.
    assert_mono_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_pop && run_q && cfg_q.mono) |-> slot_q)
        else $error("mono popped for slot 1");

    // R10: underrun is a single-cycle pulse.
    assert_underrun_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> !underrun)
        else $error("underrun longer than one cycle");

    // R4: frame sync only moves on a bit boundary or at start/stop.
    assert_fs_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q) && !$past(bit_end)) |-> $stable(fs_q))
        else $error("frame sync moved mid-bit");

endmodule

// File: rtl/audio_slot_tx.sv
// Module: top of the master-mode two-slot serial audio transmitter.
// Assumes DIV >= 2 and a single clock domain; sck is produced from the
// system clock, and all outputs come from registered state.
module audio_slot_tx
    import audio_tx_pkg::*;
#(
    parameter int DIV        = 4,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_req,
    input  logic [2:0]           cfg_size,
    input  logic                 cfg_lsb_first,
    input  logic                 cfg_strobe_rise,
    input  logic                 cfg_mono,
    input  logic                 s_valid,
    input  logic [SLOT_BITS-1:0] s_data,
    output logic                 s_ready,
    output logic                 sck,
    output logic                 fs,
    output logic                 sd,
    output logic                 en_status,
    output logic                 underrun
);
    tx_cfg_t              cfg_in;
    logic                 f_pop, f_valid, f_room, bit_end, strobe_q, run;
    logic [SLOT_BITS-1:0] f_data;

    assign cfg_in    = '{size_code: cfg_size, lsb_first: cfg_lsb_first,
                         strobe_rise: cfg_strobe_rise, mono: cfg_mono};
    assign s_ready   = f_room;
    assign en_status = run;

    audio_tx_fifo #(.WIDTH(SLOT_BITS), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (s_valid && f_room),
        .wr_data   (s_data),
        .pop       (f_pop),
        .rd_data   (f_data),
        .not_empty (f_valid),
        .not_full  (f_room)
    );

    audio_sck_timer #(.DIV(DIV)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .strobe_rise (strobe_q),
        .bit_end     (bit_end),
        .sck         (sck)
    );

    audio_slot_engine u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_req      (en_req),
        .cfg_in      (cfg_in),
        .bit_end     (bit_end),
        .fifo_valid  (f_valid),
        .fifo_data   (f_data),
        .fifo_pop    (f_pop),
        .running     (run),
        .strobe_rise (strobe_q),
        .fs          (fs),
        .sd          (sd),
        .underrun    (underrun)
    );

endmodule

// File: tb/sim_audio_slot_tx.sv
// Bench: directed and seeded-random runs; the serial line is captured at
// each sampling edge and compared with slot words built by bench functions.
module sim_audio_slot_tx;
    localparam int DIV = 6;
    localparam int CAP = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_req = 1'b0;
    logic [2:0]  cfg_size = 3'd4;
    logic        cfg_lsb_first = 1'b0, cfg_strobe_rise = 1'b0, cfg_mono = 1'b0;
    logic        s_valid = 1'b0;
    logic [31:0] s_data = '0;
    logic        s_ready, sck, fs, sd, en_status, underrun;

    audio_slot_tx #(.DIV(DIV), .FIFO_DEPTH(4)) u0 (
        .clk(clk), .rst_n(rst_n), .en_req(en_req), .cfg_size(cfg_size),
        .cfg_lsb_first(cfg_lsb_first), .cfg_strobe_rise(cfg_strobe_rise),
        .cfg_mono(cfg_mono), .s_valid(s_valid), .s_data(s_data),
        .s_ready(s_ready), .sck(sck), .fs(fs), .sd(sd),
        .en_status(en_status), .underrun(underrun)
    );

    always #4 clk = ~clk;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    logic cap_sd [CAP];
    logic cap_fs [CAP];
    int   n = 0, since_edge = 0, intv_err = 0, r3_err = 0, ur_cnt = 0;
    bit   cap_on = 1'b0, have_edge = 1'b0, cur_strobe = 1'b0;
    logic prev_sck = 1'b0, prev_sd = 1'b0, prev_fs = 1'b0, prev_st = 1'b0;
    logic edge_s;
    logic [31:0] smp [16];

    // Record the line at every sampling edge and check edge spacing/alignment.
    always @(negedge clk) begin
        if (rst_n && cap_on) begin
            edge_s = cur_strobe ? (!prev_sck && sck) : (prev_sck && !sck);
            since_edge++;
            if (edge_s) begin
                if (have_edge && since_edge != DIV) intv_err++;
                have_edge  = 1'b1;
                since_edge = 0;
                if (n < CAP) begin
                    cap_sd[n] = sd;
                    cap_fs[n] = fs;
                end
                n++;
            end
            if (prev_st && en_status && (sd !== prev_sd || fs !== prev_fs))
                if (!(sck == !cur_strobe && prev_sck == cur_strobe)) r3_err++;
        end
        if (rst_n && underrun) ur_cnt++;
        prev_sck = sck;
        prev_sd  = sd;
        prev_fs  = fs;
        prev_st  = en_status;
    end

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected slot word, first-sent bit at [31], from R1/R2.
    function automatic logic [31:0] exp_word(input logic [31:0] s,
                                             input logic [2:0] code,
                                             input logic lsb);
        int w;
        logic [31:0] r;
        case (code)
            3'd2: w = 8;   3'd3: w = 10;  3'd5: w = 20;
            3'd6: w = 24;  3'd7: w = 32;  default: w = 16;
        endcase
        r = '0;
        for (int t = 0; t < 32; t++)
            if (t < w) r[31-t] = lsb ? s[t] : s[w-1-t];
        return r;
    endfunction

    task automatic push(input logic [31:0] d);
        @(negedge clk);
        s_valid = 1'b1;
        s_data  = d;
        while (!s_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic clear_capture();
        n = 0; have_edge = 1'b0; since_edge = 0;
        intv_err = 0; r3_err = 0; ur_cnt = 0;
        cap_on = 1'b1;
    endtask

    task automatic wait_stopped();
        while (en_status) @(negedge clk);
        en_req = 1'b0;
        cap_on = 1'b0;
    endtask

    // mode 0: plain, 1: config perturbed while running, 2: enable re-raised.
    task automatic run_case(input logic [2:0] code, input logic lsb,
                            input logic strobe, input logic mono,
                            input int nf, input int mode);
        int need, pre;
        logic [31:0] got;
        bit fs_ok;
        need = mono ? nf : 2 * nf;
        @(negedge clk);
        cfg_size = code; cfg_lsb_first = lsb;
        cfg_strobe_rise = strobe; cfg_mono = mono;
        cur_strobe = strobe;
        repeat (3) @(negedge clk);
        clear_capture();
        for (int i = 0; i < need; i++) smp[i] = $urandom;
        pre = (need < 4) ? need : 4;
        for (int i = 0; i < pre; i++) push(smp[i]);
        @(negedge clk);
        s_valid = 1'b0;
        en_req  = 1'b1;
        fork
            begin
                for (int i = pre; i < need; i++) push(smp[i]);
                @(negedge clk);
                s_valid = 1'b0;
            end
            begin
                while (n < (nf - 1) * 64 + 5) @(negedge clk);
                if (mode == 1) begin
                    cfg_lsb_first = ~lsb;
                    cfg_size = (code == 3'd7) ? 3'd2 : 3'd7;
                    cfg_mono = ~mono;
                end
                en_req = 1'b0;
                @(negedge clk);
                chk(en_status == 1'b1, "R7 status held after drop", 32'(en_status), 1);
                if (mode == 2) en_req = 1'b1;
            end
        join
        wait_stopped();
        chk(n == nf * 64, (mode == 2) ? "R8 stop at frame end despite re-enable"
                                      : "R7 full frame sent", n, nf * 64);
        cfg_size = code; cfg_lsb_first = lsb; cfg_mono = mono;
        for (int k = 0; k < 2 * nf; k++) begin
            got = '0;
            fs_ok = 1'b1;
            for (int b = 0; b < 32; b++) begin
                got = {got[30:0], cap_sd[k*32+b]};
                if (cap_fs[k*32+b] !== ((k % 2) == 0)) fs_ok = 1'b0;
            end
            chk(got == exp_word(smp[mono ? k/2 : k], code, lsb),
                mono ? "R6 R1 R2 mono slot data" : "R5 R1 R2 stereo slot data",
                got, exp_word(smp[mono ? k/2 : k], code, lsb));
            chk(fs_ok, "R4 frame sync per slot", 32'(fs_ok), 1);
        end
        if (mode == 1) chk(n == nf * 64, "R9 config frozen while running", n, nf * 64);
        chk(ur_cnt == 0, "R10 no underrun when fed", ur_cnt, 0);
        chk(intv_err == 0, "R11 sck period", intv_err, 0);
        chk(r3_err == 0, "R3 data moves on drive edge", r3_err, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] z;
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        chk({en_status, fs, sd, sck, underrun} == 5'b0, "R12 reset outputs",
            {en_status, fs, sd, sck, underrun}, 0);
        chk(s_ready == 1'b1, "R12 reset ready", 32'(s_ready), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_case(3'd4, 1'b0, 1'b0, 1'b0, 3, 0);
        run_case(3'd2, 1'b1, 1'b1, 1'b0, 2, 0);
        run_case(3'd3, 1'b0, 1'b0, 1'b1, 3, 0);
        run_case(3'd5, 1'b1, 1'b0, 1'b0, 2, 0);
        run_case(3'd6, 1'b0, 1'b1, 1'b1, 2, 0);
        run_case(3'd7, 1'b1, 1'b1, 1'b0, 2, 0);
        run_case(3'd0, 1'b0, 1'b0, 1'b0, 1, 0);   // R1 reserved code as 16
        run_case(3'd1, 1'b1, 1'b0, 1'b1, 1, 0);   // R1 reserved code as 16
        run_case(3'd7, 1'b0, 1'b0, 1'b0, 3, 1);   // R9
        run_case(3'd4, 1'b0, 1'b1, 1'b0, 3, 2);   // R8
        for (int r = 0; r < 4; r++)
            run_case(3'(2 + $urandom % 6), 1'($urandom), 1'($urandom),
                     1'($urandom), 1 + int'($urandom % 3), 0);

        // R10: empty FIFO, one stereo frame of zeros with two pulses.
        @(negedge clk);
        cfg_size = 3'd4; cfg_lsb_first = 1'b0; cfg_strobe_rise = 1'b0; cfg_mono = 1'b0;
        cur_strobe = 1'b0;
        repeat (3) @(negedge clk);
        clear_capture();
        en_req = 1'b1;
        while (n < 5) @(negedge clk);
        en_req = 1'b0;
        wait_stopped();
        chk(n == 64, "R10 underrun frame length", n, 64);
        z = '0;
        for (int b = 0; b < 64 && b < n; b++) z = z | 32'(cap_sd[b]);
        chk(z == 0, "R10 underrun slots carry zeros", z, 0);
        chk(ur_cnt == 2, "R10 one pulse per starved slot", ur_cnt, 2);
        chk(sck == 1'b0 && en_status == 1'b0, "R3 idle sck level",
            {sck, en_status}, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule